// File: doc/BRIEF.md
# Watchdog Timer with Change-Triggered Reload

The block is a 32-bit up-counting watchdog. Once enabled, the counter advances on ticks from an optional power-of-two prescaler. When a tick finds the counter at all-ones, the counter wraps. That wrap is an overflow: the block raises a reset output for a fixed number of cycles and reloads the counter from a load register. Software keeps the system alive by writing to a trigger register before the counter gets that far. Such a write restarts the count from the load value and clears the prescaler. It only counts as a kick when the written data differs from what the trigger register already holds, so a stuck writer that repeats one value cannot hold off a reset.

Four registers sit behind a simple valid/write strobe with a 2-bit address:

- **Address 0:** the live count, read-only.
- **Address 1:** the load value.
- **Address 2:** the trigger register.
- **Address 3:** control (enable and prescaler).

A new load value is never applied to the running count. It is used at the next reload, whichever kind of reload that is. Read data is combinational from the addressed register.

Top module: `wdt_top`

## Requirements
- R1: With the enable bit set and the prescaler off, the counter increases by one on every clock.
- R2: Reading address 0 returns the current count in the same cycle at any time, and writes to address 0 are ignored.
- R3: A write to the load register (address 1) leaves the running count unchanged; the new value is used only at the next reload.
- R4: With the prescaler on and select value N, the counter advances once every 2^N clocks.
- R5: A write to the trigger register (address 2) of the value it already holds has no effect: the count keeps running and the prescaler is not cleared.
- R6: A write to the trigger register of a different value stores it, loads the counter from the load register on that edge, clears the prescaler and produces no reset pulse.
- R7: An enabled tick with the counter at 0xFFFFFFFF loads the counter from the load register, and the reset output is high for exactly 4 cycles, starting the cycle after that edge.
- R8: While the enable bit is clear, the counter and prescaler hold their values and no reset pulse starts.
- R9: When a trigger reload and an overflow fall in the same cycle, the reload is taken and no reset pulse is produced.
- R10: After system reset, the counter, load and trigger registers read zero, the control register reads zero (disabled), and the reset output is low.
- R11: The control register at address 3 reads back its fields with all other bits zero:
  - bit 0: enable.
  - bit 1: prescaler on.
  - bits 4:2: prescaler select N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_write | input | 1 | Access is a write when high |
| bus_addr | input | 2 | Register address (0 count, 1 load, 2 trigger, 3 control) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed register |
| wdt_rst_out | output | 1 | Reset pulse produced on overflow |

## Verification
The assertions assume that at most one register access arrives per cycle, carried on a single address. Under that assumption, a trigger reload can never share an edge with a load write. They also take the bus inputs as stable around the rising edge. The stimulus drives each access at the falling edge and holds it for a full cycle. It issues a single access per step. Random load values are biased toward the top of the range, so overflows, back-to-back overflows and reload-versus-overflow collisions occur often within a short run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CNT_W_DEF    = 32;
    localparam int SEL_W_DEF    = 3;
    localparam int PULSE_LEN    = 4;

    typedef enum logic [1:0] {
        ADDR_COUNT = 2'd0,
        ADDR_LOAD  = 2'd1,
        ADDR_TRIG  = 2'd2,
        ADDR_CTRL  = 2'd3
    } wdt_addr_e;

    typedef struct packed {
        logic [SEL_W_DEF-1:0] psel;
        logic                 pre_on;
        logic                 run;
    } wdt_ctrl_t;

    localparam int CTRL_W = $bits(wdt_ctrl_t);

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0] count_val,
    output logic [CNT_W-1:0] bus_rdata,
    output logic [CNT_W-1:0] load_val,
    output wdt_ctrl_t        ctrl,
    output logic             kick
);
    logic [CNT_W-1:0] trig_q;
    logic             wr_en;

    assign wr_en = bus_valid && bus_write;
    assign kick  = wr_en && (wdt_addr_e'(bus_addr) == ADDR_TRIG) && (bus_wdata != trig_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q   <= '0;
            load_val <= '0;
            ctrl     <= '0;
        end else if (wr_en) begin
            case (wdt_addr_e'(bus_addr))
                ADDR_LOAD: load_val <= bus_wdata;
                ADDR_TRIG: trig_q   <= bus_wdata;
                ADDR_CTRL: ctrl     <= wdt_ctrl_t'(bus_wdata[CTRL_W-1:0]);
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (wdt_addr_e'(bus_addr))
            ADDR_COUNT: bus_rdata = count_val;
            ADDR_LOAD:  bus_rdata = load_val;
            ADDR_TRIG:  bus_rdata = trig_q;
            default:    bus_rdata = CNT_W'(ctrl);
        endcase
    end

    // R5: an unchanged trigger value never raises a reload
    a_r5_same_no_kick: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdt_addr_e'(bus_addr) == ADDR_TRIG && bus_wdata == trig_q) |-> !kick);

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int SEL_W = SEL_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             pre_on,
    input  logic [SEL_W-1:0] psel,
    input  logic             clear,
    output logic             tick
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] limit;

    assign limit = {DIV_W{1'b1}} >> (DIV_W - int'(psel));
    assign tick  = run && (!pre_on || div_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            div_q <= '0;
        end else if (run && pre_on) begin
            div_q <= tick ? '0 : div_q + 1'b1;
        end
    end

    // R8: no tick while stopped
    a_r8_no_tick_stopped: assert property (@(posedge clk) disable iff (rst)
        !run |-> !tick);
    // R8: divider holds while stopped
    a_r8_div_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !clear) |=> $stable(div_q));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             kick,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    assign ovf = tick && !kick && (count == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (kick || ovf) begin
            count <= load_val;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

    // R1: a plain tick advances by exactly one
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !kick && count != {CNT_W{1'b1}}) |=> count == $past(count) + 1'b1);
    // R6: a kick loads the load value
    a_r6_kick_loads: assert property (@(posedge clk) disable iff (rst)
        kick |=> count == $past(load_val));
    // R7: overflow reloads from the load value
    a_r7_ovf_loads: assert property (@(posedge clk) disable iff (rst)
        ovf |=> count == $past(load_val));
    // R8: no tick, no kick means the count holds
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !kick) |=> $stable(count));

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);
    localparam int PW = $clog2(LEN + 1);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= PW'(LEN);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign pulse = (left_q != '0);

    // R7: the output follows every overflow on the next cycle
    a_r7_pulse_starts: assert property (@(posedge clk) disable iff (rst)
        fire |=> pulse);
    // R7: the output only rises after an overflow
    a_r7_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> $past(fire));

endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int SEL_W = SEL_W_DEF,
    parameter int PLEN  = PULSE_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             wdt_rst_out
);
    wdt_ctrl_t        ctrl;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] count;
    logic             kick;
    logic             tick;
    logic             ovf;

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .count_val(count), .bus_rdata(bus_rdata),
        .load_val(load_val), .ctrl(ctrl), .kick(kick)
    );

    wdt_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst(rst),
        .run(ctrl.run), .pre_on(ctrl.pre_on), .psel(ctrl.psel),
        .clear(kick), .tick(tick)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst),
        .tick(tick), .kick(kick), .load_val(load_val),
        .count(count), .ovf(ovf)
    );

    wdt_pulse #(.LEN(PLEN)) u_pulse (
        .clk(clk), .rst(rst), .fire(ovf), .pulse(wdt_rst_out)
    );

    // R9: a reload in the same cycle suppresses the overflow
    a_r9_kick_wins: assert property (@(posedge clk) disable iff (rst)
        kick |-> !ovf);
    // R8: a stopped watchdog never starts a pulse
    a_r8_no_ovf_stopped: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |-> !ovf);

endmodule

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid;
    logic        bus_write;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        wdt_rst_out;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model state
    logic [31:0] m_cnt, m_load, m_trig;
    logic [4:0]  m_ctrl;
    logic [6:0]  m_div;
    int          m_left;

    always #2 clk = ~clk;

    wdt_top dut (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdt_rst_out(wdt_rst_out)
    );

    function automatic logic [6:0] lim_of(input logic [2:0] n);
        return 7'((32'd1 << n) - 1);
    endfunction

    function automatic logic m_tick();
        return m_ctrl[0] && (!m_ctrl[1] || m_div >= lim_of(m_ctrl[4:2]));
    endfunction

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_cnt;
            2'd1: return m_load;
            2'd2: return m_trig;
            default: return {27'd0, m_ctrl};
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = '0; m_load = '0; m_trig = '0; m_ctrl = '0; m_div = '0; m_left = 0;
    endtask

    task automatic model_edge(input logic v, input logic w, input logic [1:0] a, input logic [31:0] d);
        logic wr, kick, tk, ovf;
        wr   = v && w;
        kick = wr && a == 2'd2 && d != m_trig;
        tk   = m_tick();
        ovf  = tk && !kick && m_cnt == 32'hFFFF_FFFF;
        if (kick || ovf)  m_cnt = m_load;
        else if (tk)      m_cnt = m_cnt + 1;
        if (kick) m_div = '0;
        else if (m_ctrl[0] && m_ctrl[1]) m_div = tk ? 7'd0 : m_div + 1;
        if (ovf) m_left = 4;
        else if (m_left > 0) m_left--;
        if (wr) begin
            case (a)
                2'd1: m_load = d;
                2'd2: m_trig = d;
                2'd3: m_ctrl = d[4:0];
                default: ;
            endcase
        end
    endtask

    // one bus cycle; a read also compares rdata, every cycle compares the pulse
    task automatic step(input string req, input logic v, input logic w, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
        #1;
        check("R7", "rst_out", {31'd0, wdt_rst_out}, {31'd0, m_left != 0});
        if (!(v && w)) check(req, "rdata", bus_rdata, m_read(a));
        @(posedge clk);
        model_edge(v, w, a, d);
    endtask

    task automatic wr(input string req, input logic [1:0] a, input logic [31:0] d);
        step(req, 1'b1, 1'b1, a, d);
    endtask

    task automatic rd(input string req, input logic [1:0] a);
        step(req, 1'b1, 1'b0, a, 32'd0);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_bad++;
                $display("FAIL watchdog: run did not finish, actual %0d expected <150000", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] rv;
        void'($urandom(32'd20240611));
        bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
        rst = 1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R10: reset values
        for (int i = 0; i < 4; i++) rd("R10", 2'(i));

        // R3: load write does not disturb the count
        wr("R3", 2'd1, 32'hFFFF_FFF8);
        wr("R1", 2'd3, 32'h1);
        rd("R1", 2'd0); rd("R1", 2'd0);
        rd("R3", 2'd0);
        // R2: writes to count ignored
        wr("R2", 2'd0, 32'h1234_5678);
        rd("R2", 2'd0);
        // R6: differing trigger reloads
        wr("R6", 2'd2, 32'h5);
        rd("R6", 2'd0); rd("R6", 2'd2);
        // R5: same trigger value has no effect
        wr("R5", 2'd2, 32'h5);
        rd("R5", 2'd0);
        // R7: run through overflow and pulse
        for (int i = 0; i < 16; i++) rd("R7", 2'd0);
        // R8: stop and hold
        wr("R8", 2'd3, 32'h0);
        for (int i = 0; i < 5; i++) rd("R8", 2'd0);
        // R4 and R11: prescaler by 4
        wr("R11", 2'd3, 32'hFFFF_FF00 | 32'h0B);
        rd("R11", 2'd3);
        for (int i = 0; i < 12; i++) rd("R4", 2'd0);
        // R9: reload collides with overflow
        wr("R9", 2'd3, 32'h1);
        wr("R9", 2'd1, 32'hFFFF_FFFE);
        wr("R9", 2'd2, 32'h77);
        rd("R9", 2'd0);
        wr("R9", 2'd2, 32'h78);
        for (int i = 0; i < 6; i++) rd("R9", 2'd0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int sel;
            sel = int'($urandom_range(0, 99));
            if (sel < 45) begin
                rd("R2", 2'($urandom_range(0, 3)));
            end else if (sel < 60) begin
                rv = ($urandom_range(0, 1) == 0) ? m_trig : $urandom_range(0, 15);
                wr("R6", 2'd2, rv);
            end else if (sel < 72) begin
                rv = 32'hFFFF_FFFF - $urandom_range(0, 40);
                wr("R3", 2'd1, rv);
            end else if (sel < 78) begin
                rv = ($urandom_range(0, 5) == 0) ? 32'h0 : {27'd0, 3'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'b1};
                wr("R4", 2'd3, rv);
            end else begin
                step("R1", 1'b0, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), $urandom);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule